// File: doc/BRIEF.md
# CEC Receive Frame Buffer

This block is the receive-side storage of a register-mapped CEC controller. A bit-level line engine upstream delivers each received frame as a stream of bytes. It raises a valid strobe for every byte and marks the final byte of the frame. The buffer keeps up to two complete frames. The first byte of a frame is the header: the initiator address is in bits 7:4 and the follower address is in bits 3:0. The second byte is the opcode, and up to 14 operand bytes follow.

The host sees the oldest stored frame through a small register window:
- a data window of 16 byte registers,
- a length register holding the byte count minus one,
- a status register,
- a stored-frame count register,
- a receive command register,
- a clear register.

The host pins the oldest frame with a read command, then reads the length and the data bytes. It releases the frame with a stop command, which exposes the next stored frame. The buffer can be emptied in two ways: the abort-and-clear command, or writing 1 then 0 to the clear register. A disable command stops new frames from being accepted and keeps the frames already stored.

Register reads are combinational from `reg_addr`. Register writes take effect on the rising clock edge on which `reg_wr` is high. Bit timing and address filtering are done upstream.

Top module: `cec_rx_frame_buf`

## Requirements
- R1: After reset the count register (index 82) reads 0, the status register (index 81) reads 0 (idle), and the length register (index 80) and data register 64 read 0.
- R2: When the final byte of a frame is accepted, the count goes up by one and the status reads 2 (success). Data register 64+i returns byte i of the oldest frame, and the length register returns the byte count minus one, so a 16-byte frame reads 15.
- R3: Writing 1 (read) and then 0 (stop) to the command register (index 20, bits 1:0) releases the oldest frame. The count goes down by one, and the next stored frame becomes visible in arrival order.
- R4: A stop command that is not preceded by a read command since the last release does not release any frame.
- R5: A frame whose first byte arrives while two frames are stored is dropped completely. The two stored frames and the count of 2 are unchanged.
- R6: Command 2 (disable) makes every frame that starts afterwards be ignored, and the stored frames are kept. A later stop or read command enables reception again.
- R7: Command 3 (abort-and-clear) sets the count to 0 and drops the frame currently being received, including all of its remaining bytes.
- R8: Writing 1 and then 0 to bit 0 of the clear register (index 21) empties the buffer. Writing 1 alone leaves the stored frames in place.
- R9: While the buffer is empty and an accepted frame is partly received, the status reads 1 (busy).
- R10: A frame of more than 16 bytes is dropped entirely and does not change the count.
- R11: Data registers beyond the stored length of the oldest frame read 0, and all data registers read 0 while the buffer is empty.
- R12: If a frame completes in the same cycle as a release, the count is unchanged and the newly completed frame is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |

## Verification
The hardest situation to reach from the ports is a frame completing in exactly the cycle in which the host releases the oldest frame. In that cycle the count must both rise and fall. The bench first stores one frame and pins it with a read command. It then drives the next frame's bytes so that the final byte and the stop write land on the same clock edge. Finally it checks that the count stays at one and that the new frame is now the visible one. The second hard case is an abort that arrives in the middle of a frame. The bench reaches it by sending only part of a frame, issuing the abort, and then sending the rest of the frame, which must not be stored.

// File: rtl/cec_rxb_pkg.sv
// Shared register indices and code values for the CEC receive frame buffer.
package cec_rxb_pkg;

    localparam int AW = 7;
    localparam int DW = 8;

    localparam logic [AW-1:0] A_RX_CMD = 7'd20;
    localparam logic [AW-1:0] A_RX_CLR = 7'd21;
    localparam logic [AW-1:0] A_DATA0  = 7'd64;
    localparam logic [AW-1:0] A_LEN    = 7'd80;
    localparam logic [AW-1:0] A_STAT   = 7'd81;
    localparam logic [AW-1:0] A_CNT    = 7'd82;

    typedef enum logic [1:0] {
        CMD_STOP    = 2'd0,
        CMD_READ    = 2'd1,
        CMD_DISABLE = 2'd2,
        CMD_ABORT   = 2'd3
    } rx_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_OK   = 2'd2,
        ST_ERR  = 2'd3
    } rx_stat_e;

endpackage

// File: rtl/cec_rxb_ctrl.sv
// Host command decoder.
// Turns writes to the command and clear registers into a release pulse,
// a flush pulse and the receive-enable level.
// Assumes single-cycle write strobes. A release is only produced when a
// read command has pinned a frame and the buffer holds at least one frame.
module cec_rxb_ctrl
    import cec_rxb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [1:0]    cmd_bits,
    input  logic          clr_bit,
    input  logic          buf_empty,
    output logic          rx_en,
    output logic          pop,
    output logic          flush
);

    logic    pinned;
    logic    clr_armed;
    logic    cmd_hit;
    logic    clr_hit;
    rx_cmd_e cmd;

    // Decode the write strobe into command and clear hits.
    always_comb begin
        cmd_hit = reg_wr && (reg_addr == A_RX_CMD);
        clr_hit = reg_wr && (reg_addr == A_RX_CLR);
        cmd     = rx_cmd_e'(cmd_bits);
    end

    // Release and flush pulses for the frame store and the intake.
    always_comb begin
        pop   = cmd_hit && (cmd == CMD_STOP) && pinned && !buf_empty;
        flush = (cmd_hit && (cmd == CMD_ABORT))
              || (clr_hit && !clr_bit && clr_armed);
    end

    // Track the pin, the receive enable and the armed half of the clear sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pinned    <= 1'b0;
            rx_en     <= 1'b1;
            clr_armed <= 1'b0;
        end else begin
            if (cmd_hit) begin
                case (cmd)
                    CMD_STOP:    begin pinned <= 1'b0; rx_en <= 1'b1; end
                    CMD_READ:    begin pinned <= 1'b1; rx_en <= 1'b1; end
                    CMD_DISABLE: rx_en  <= 1'b0;
                    CMD_ABORT:   pinned <= 1'b0;
                    default:     pinned <= pinned;
                endcase
            end
            if (clr_hit) begin
                clr_armed <= clr_bit;
                if (!clr_bit && clr_armed) pinned <= 1'b0;
            end
        end
    end

    // R6: a disable command turns reception off on the next cycle.
    a_r6_disable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && cmd == CMD_DISABLE) |=> !rx_en);

    // R4: a stop written without a pinned frame never releases.
    a_r4_stop_unpinned: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && cmd == CMD_STOP && !pinned) |-> !pop);

endmodule

// File: rtl/cec_rxb_intake.sv
// Frame intake.
// Follows the byte stream from the line engine, decides at the first byte
// of each frame whether the frame is kept, writes kept bytes into the free
// slot, and issues a commit with the frame's length (byte count minus one)
// on the final byte.
// Assumes the free slot stays free for the whole frame, which holds because
// only a commit can fill it.
module cec_rxb_intake #(
    parameter int MAXB = 16,
    parameter int DW   = 8,
    localparam int IDXW = $clog2(MAXB),
    localparam int PCW  = $clog2(MAXB + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [DW-1:0]   in_byte,
    input  logic            in_last,
    input  logic            rx_en,
    input  logic            buf_full,
    input  logic            cancel,
    output logic            wr_en,
    output logic [IDXW-1:0] wr_idx,
    output logic [DW-1:0]   wr_byte,
    output logic            commit,
    output logic [IDXW-1:0] commit_len,
    output logic            receiving
);

    logic           in_frame;
    logic           keep;
    logic [PCW-1:0] pos;
    logic [PCW-1:0] pos_eff;
    logic           take;
    logic           fits;

    // Position and keep decision for the byte presented this cycle.
    always_comb begin
        pos_eff    = in_frame ? pos : '0;
        take       = in_frame ? keep : (rx_en && !buf_full);
        fits       = pos_eff < PCW'(MAXB);
        wr_en      = in_valid && take && fits && !cancel;
        wr_idx     = pos_eff[IDXW-1:0];
        wr_byte    = in_byte;
        commit     = wr_en && in_last;
        commit_len = pos_eff[IDXW-1:0];
        receiving  = in_frame && keep;
    end

    // Advance through the frame; an overlong or cancelled frame stops being kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            keep     <= 1'b0;
            pos      <= '0;
        end else if (in_valid) begin
            if (in_last) begin
                in_frame <= 1'b0;
                keep     <= 1'b0;
                pos      <= '0;
            end else begin
                in_frame <= 1'b1;
                keep     <= take && fits && !cancel;
                pos      <= fits ? pos_eff + 1'b1 : pos_eff;
            end
        end else if (cancel) begin
            keep <= 1'b0;
        end
    end

    // R5: no byte is written while both slots are occupied.
    a_r5_write_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !buf_full);

    // R7: after a cancel the current frame is no longer being kept.
    a_r7_cancel_drops: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> !receiving);

    // R10: a byte past the size limit never completes a frame.
    a_r10_long_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_frame && pos == PCW'(MAXB)) |-> !commit);

endmodule

// File: rtl/cec_rxb_slots.sv
// Frame slot store.
// A ring of SLOTS frame slots, each holding MAXB bytes and a length.
// Keeps the write pointer, the read pointer and the stored-frame count,
// and returns the oldest frame's byte at rd_idx together with its length.
// Assumes commit is never raised when full and pop never when empty.
module cec_rxb_slots #(
    parameter int SLOTS = 2,
    parameter int MAXB  = 16,
    parameter int DW    = 8,
    localparam int IDXW = $clog2(MAXB),
    localparam int PW   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNTW = $clog2(SLOTS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [DW-1:0]   wr_byte,
    input  logic            commit,
    input  logic [IDXW-1:0] commit_len,
    input  logic            pop,
    input  logic            flush,
    input  logic [IDXW-1:0] rd_idx,
    output logic [CNTW-1:0] count,
    output logic            full,
    output logic            empty,
    output logic [DW-1:0]   rd_byte,
    output logic [IDXW-1:0] rd_len
);

    logic [DW-1:0]   mem  [SLOTS][MAXB];
    logic [IDXW-1:0] lens [SLOTS];
    logic [PW-1:0]   wr_ptr;
    logic [PW-1:0]   rd_ptr;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    // Occupancy flags and read-out of the oldest frame.
    always_comb begin
        full    = (count == CNTW'(SLOTS));
        empty   = (count == '0);
        rd_byte = mem[rd_ptr][rd_idx];
        rd_len  = lens[rd_ptr];
    end

    // Pointer and count bookkeeping; a flush wins over everything else.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (commit) wr_ptr <= step(wr_ptr);
            if (pop)    rd_ptr <= step(rd_ptr);
            case ({commit, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Byte and length storage for the slot being filled.
    always_ff @(posedge clk) begin
        if (wr_en)  mem[wr_ptr][wr_idx] <= wr_byte;
        if (commit) lens[wr_ptr]        <= commit_len;
    end

    // R2: a lone commit adds one frame.
    a_r2_commit_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !pop && !flush) |=> count == CNTW'($past(count) + 1'b1));

    // R3: a lone release removes one frame.
    a_r3_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !commit && !flush) |=> count == CNTW'($past(count) - 1'b1));

    // R12: a commit and a release together leave the count alone.
    a_r12_swap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && pop && !flush) |=> $stable(count));

    // R7: a flush leaves the store empty.
    a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

    // R5: the intake never commits into a full store.
    a_r5_room_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !full);

endmodule

// File: rtl/cec_rx_frame_buf.sv
// CEC receive frame buffer, top level.
// Connects the byte intake, the slot store and the host command decoder,
// and drives the combinational register read-back: data window, length,
// status and stored-frame count.
// Assumes reg_addr is stable while reg_rdata is sampled.
module cec_rx_frame_buf
    import cec_rxb_pkg::*;
#(
    parameter int SLOTS = 2,
    parameter int MAXB  = 16,
    localparam int IDXW = $clog2(MAXB),
    localparam int CNTW = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_last,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata
);

    logic            rx_en, pop, flush;
    logic            wr_en, commit, receiving;
    logic [IDXW-1:0] wr_idx, commit_len, rd_len, win_idx;
    logic [DW-1:0]   wr_byte, rd_byte;
    logic [CNTW-1:0] count;
    logic            full, empty;
    logic [AW-1:0]   win_off;
    logic            in_window;
    logic            unused_wdata;

    assign unused_wdata = ^reg_wdata[DW-1:2];

    cec_rxb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .cmd_bits  (reg_wdata[1:0]),
        .clr_bit   (reg_wdata[0]),
        .buf_empty (empty),
        .rx_en     (rx_en),
        .pop       (pop),
        .flush     (flush)
    );

    cec_rxb_intake #(.MAXB(MAXB), .DW(DW)) u_intake (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (rx_valid),
        .in_byte    (rx_byte),
        .in_last    (rx_last),
        .rx_en      (rx_en),
        .buf_full   (full),
        .cancel     (flush),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_byte    (wr_byte),
        .commit     (commit),
        .commit_len (commit_len),
        .receiving  (receiving)
    );

    cec_rxb_slots #(.SLOTS(SLOTS), .MAXB(MAXB), .DW(DW)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_byte    (wr_byte),
        .commit     (commit),
        .commit_len (commit_len),
        .pop        (pop),
        .flush      (flush),
        .rd_idx     (win_idx),
        .count      (count),
        .full       (full),
        .empty      (empty),
        .rd_byte    (rd_byte),
        .rd_len     (rd_len)
    );

    // Locate the address inside the data window.
    always_comb begin
        win_off   = reg_addr - A_DATA0;
        in_window = (reg_addr >= A_DATA0) && (win_off < AW'(MAXB));
        win_idx   = win_off[IDXW-1:0];
    end

    // Register read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (in_window) begin
            if (!empty && win_idx <= rd_len) reg_rdata = rd_byte;
        end else begin
            case (reg_addr)
                A_LEN:   if (!empty) reg_rdata = DW'(rd_len);
                A_STAT:  reg_rdata = DW'(!empty ? ST_OK : (receiving ? ST_BUSY : ST_IDLE));
                A_CNT:   reg_rdata = DW'(count);
                default: reg_rdata = '0;
            endcase
        end
    end

    // R9: a partly received frame in an empty buffer reports busy.
    a_r9_busy_when_filling: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_STAT && empty && receiving) |-> reg_rdata == DW'(ST_BUSY));

endmodule

// File: tb/tb_cec_rx_frame_buf.sv
`timescale 1ns/1ps
module tb_cec_rx_frame_buf;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_last = 1'b0;
    logic       reg_wr = 1'b0;
    logic [6:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam int NV = 6;
    localparam int V_LEN  [NV] = '{1, 2, 16, 5, 9, 3};
    localparam int V_SEED [NV] = '{8'h4F, 8'h10, 8'h03, 8'hE1, 8'h7A, 8'h25};

    always #10 clk = ~clk;

    cec_rx_frame_buf dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_last(rx_last), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] fbyte(input int seed, input int i);
        return 8'(seed + i * 7);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output int v);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic send(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_byte = fbyte(seed, i); rx_last = (i == n - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic release_oldest();
        wr(7'd20, 8'd1);
        wr(7'd20, 8'd0);
    endtask

    task automatic expect_frame(input string tag, input int n, input int seed);
        int v;
        rd(7'd80, v);
        check({tag, " length"}, v, n - 1);
        for (int i = 0; i < n; i++) begin
            rd(7'(64 + i), v);
            check({tag, " byte"}, v, int'(fbyte(seed, i)));
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(7'd82, v); check("R1 count", v, 0);
        rd(7'd81, v); check("R1 status", v, 0);
        rd(7'd80, v); check("R1 length", v, 0);
        rd(7'd64, v); check("R1 data", v, 0);

        // R2 / R3: table of frames, each stored, read back and released
        for (int k = 0; k < NV; k++) begin
            send(V_LEN[k], V_SEED[k]);
            rd(7'd82, v); check("R2 count", v, 1);
            rd(7'd81, v); check("R2 status", v, 2);
            expect_frame("R2", V_LEN[k], V_SEED[k]);
            release_oldest();
            rd(7'd82, v); check("R3 count after release", v, 0);
            rd(7'd81, v); check("R3 status idle", v, 0);
        end

        // R3 / R5: order of two frames, third dropped
        send(4, 8'h30); send(6, 8'h90); send(3, 8'hC0);
        rd(7'd82, v); check("R5 count full", v, 2);
        expect_frame("R5 first kept", 4, 8'h30);
        release_oldest();
        rd(7'd82, v); check("R3 count", v, 1);
        expect_frame("R3 next exposed", 6, 8'h90);
        release_oldest();
        rd(7'd82, v); check("R5 third dropped", v, 0);

        // R11: bytes past the length read zero
        send(9, 8'h11); send(9, 8'h22);
        release_oldest(); release_oldest();
        rd(7'd64, v); check("R11 empty data", v, 0);
        send(3, 8'h55);
        rd(7'd66, v); check("R11 in range", v, int'(fbyte(8'h55, 2)));
        rd(7'd69, v); check("R11 past length", v, 0);
        release_oldest();

        // R4: stop without read keeps the frame
        send(2, 8'hA0);
        wr(7'd20, 8'd0);
        rd(7'd82, v); check("R4 unpinned stop", v, 1);
        release_oldest();
        rd(7'd82, v); check("R4 pinned stop", v, 0);

        // R6: disable keeps stored frames and blocks new ones
        send(3, 8'h61);
        wr(7'd20, 8'd2);
        send(5, 8'h62);
        rd(7'd82, v); check("R6 blocked", v, 1);
        wr(7'd20, 8'd0);
        rd(7'd82, v); check("R6 stop no release", v, 1);
        send(4, 8'h63);
        rd(7'd82, v); check("R6 reenabled", v, 2);
        expect_frame("R6 stored kept", 3, 8'h61);
        release_oldest();
        expect_frame("R6 after enable", 4, 8'h63);
        release_oldest();

        // R7: abort in the middle of a frame
        send(2, 8'h70);
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h01; rx_last = 1'b0;
        @(negedge clk); rx_byte = 8'h02;
        @(negedge clk); rx_valid = 1'b0;
        wr(7'd20, 8'd3);
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h03; rx_last = 1'b1;
        @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
        rd(7'd82, v); check("R7 abort empties", v, 0);
        rd(7'd81, v); check("R7 status idle", v, 0);
        send(2, 8'h71);
        rd(7'd82, v); check("R7 recovers", v, 1);
        release_oldest();

        // R8: clear sequence
        send(3, 8'h80);
        wr(7'd21, 8'd1);
        rd(7'd82, v); check("R8 half sequence", v, 1);
        wr(7'd21, 8'd0);
        rd(7'd82, v); check("R8 cleared", v, 0);

        // R9: busy while first frame is arriving
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h91; rx_last = 1'b0;
        @(negedge clk); rx_valid = 1'b0;
        rd(7'd81, v); check("R9 busy", v, 1);
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h92; rx_last = 1'b1;
        @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
        rd(7'd81, v); check("R9 success", v, 2);
        rd(7'd80, v); check("R9 length", v, 1);
        release_oldest();

        // R10: overlong frame dropped, 16 bytes accepted
        send(17, 8'hB0);
        rd(7'd82, v); check("R10 overlong dropped", v, 0);
        send(16, 8'hB1);
        rd(7'd82, v); check("R10 max accepted", v, 1);
        rd(7'd80, v); check("R10 max length", v, 15);
        release_oldest();

        // R12: completion and release on the same edge
        send(3, 8'hD0);
        wr(7'd20, 8'd1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_byte = fbyte(8'hD8, i); rx_last = (i == 3);
            if (i == 3) begin
                reg_wr = 1'b1; reg_addr = 7'd20; reg_wdata = 8'd0;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; reg_wr = 1'b0;
        rd(7'd82, v); check("R12 count held", v, 1);
        expect_frame("R12 new frame", 4, 8'hD8);
        release_oldest();
        rd(7'd82, v); check("R12 final empty", v, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule